// File: doc/BRIEF.md
# Colored-Button Code Lock Controller

This controller opens a door lock after one start press followed by four colored presses in the right order: red, blue, green, red. It has three colored buttons, a start button and a summary flag. The summary flag is high in any cycle in which some colored button is pressed. An upstream stage turns each press into a pulse one clock long. The controller is a Moore machine. Its states are: idle, armed (with a progress index into the code), and open. The unlock output is decoded from the open state only.

A step of the code counts only when exactly one color is pressed and that color is the one expected. Pressing several colors together therefore never satisfies a step. Cycles with no colored press leave the progress unchanged, so the user may pause between presses. A colored press that does not satisfy the current step sends the machine back to idle. The code is a parameter: one 2-bit color code per step, stored with step 0 in the lowest bits.

Top module: `color_code_lock`

## Requirements
- R1: While rst_ni is low, the machine is idle and unlock_o is 0. The release of reset is synchronized through two flops, so the machine acts on inputs from the third rising edge after rst_ni goes high.
- R2: In idle, only start_i=1 moves the machine to armed, at progress step 0. Colored presses made without a start never raise unlock_o.
- R3: While armed, a cycle with any_i=0 keeps both the state and the progress. This holds whatever levels the color and start inputs have in that cycle.
- R4: While armed, a step advances only when any_i=1 and exactly the expected color input is 1. The default code is red, blue, green, red. Color codes are red=0, green=1 and blue=2; step k sits in CODE_SEQ[2k+1:2k].
- R5: While armed, a cycle with any_i=1 that does not match the expected color exactly returns the machine to idle and discards the progress. This covers a wrong color, several colors at once, and no color at all.
- R6: unlock_o is 1 in the single cycle that follows the clock edge which captured the final correct press. It is 0 in every other cycle. The machine is idle one cycle later.
- R7: A start press while armed has no effect on the sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; release is synchronized |
| start_i | input | 1 | Start button pulse |
| red_i | input | 1 | Red button level |
| green_i | input | 1 | Green button level |
| blue_i | input | 1 | Blue button level |
| any_i | input | 1 | High when some colored button is pressed this cycle |
| unlock_o | output | 1 | Unlock strobe, high only in the open state |

## Verification
The bench presses two colors together during a step. A design that tested only the expected color would accept this press and could still open the lock. The bench also leaves a color level high while any_i is low, and presses start in the middle of a sequence. A machine that used the color lines alone, or that re-armed on start, would then lose its progress or jump back to step 0. Further cases cover a wrong first color, a press with any_i high but no color, and long pauses between presses. A fresh sequence always follows a failure or an unlock, so any progress left over from an earlier attempt would show up as an early or missing unlock pulse.

// File: rtl/color_lock_pkg.sv
package color_lock_pkg;
  localparam int unsigned NUM_COLORS = 3;
  localparam int unsigned COLOR_W    = 2;

  typedef enum logic [COLOR_W-1:0] {
    COL_RED   = 2'd0,
    COL_GREEN = 2'd1,
    COL_BLUE  = 2'd2
  } color_e;

  typedef enum logic [1:0] {
    LK_IDLE  = 2'd0,
    LK_ARMED = 2'd1,
    LK_OPEN  = 2'd2
  } lock_state_e;
endpackage

// File: rtl/lock_rst_sync.sv
module lock_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/press_decode.sv
module press_decode
  import color_lock_pkg::*;
(
  input  logic                  any_i,
  input  logic [NUM_COLORS-1:0] color_i,
  output logic [NUM_COLORS-1:0] excl_o
);
  for (genvar c = 0; c < NUM_COLORS; c++) begin : g_col
    localparam logic [NUM_COLORS-1:0] SelfMask = NUM_COLORS'(1) << c;
    logic others;
    assign others    = |(color_i & ~SelfMask);
    assign excl_o[c] = any_i & color_i[c] & ~others;
  end
endmodule

// File: rtl/code_select.sv
module code_select
  import color_lock_pkg::*;
#(
  parameter int unsigned               CODE_LEN = 4,
  parameter logic [CODE_LEN*COLOR_W-1:0] CODE_SEQ = 8'b00_01_10_00,
  localparam int unsigned              IDX_W    = $clog2(CODE_LEN)
) (
  input  logic [IDX_W-1:0]      idx_i,
  input  logic [NUM_COLORS-1:0] excl_i,
  output logic                  hit_o
);
  localparam int unsigned PadW = 1 << COLOR_W;

  logic [PadW-1:0]     excl_pad;
  logic [CODE_LEN-1:0] hit_k;

  assign excl_pad = PadW'(excl_i);

  for (genvar k = 0; k < CODE_LEN; k++) begin : g_step
    localparam logic [COLOR_W-1:0] StepColor = CODE_SEQ[k*COLOR_W +: COLOR_W];
    assign hit_k[k] = (idx_i == IDX_W'(k)) & excl_pad[StepColor];
  end

  assign hit_o = |hit_k;
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
  import color_lock_pkg::*;
#(
  parameter  int unsigned CODE_LEN = 4,
  localparam int unsigned IDX_W    = $clog2(CODE_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             any_i,
  input  logic             hit_i,
  output lock_state_e      st_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LastIdx = IDX_W'(CODE_LEN - 1);

  lock_state_e      st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             st_en, idx_en;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    unique case (st_q)
      LK_IDLE: begin
        if (start_i) begin
          st_d  = LK_ARMED;
          idx_d = '0;
        end
      end
      LK_ARMED: begin
        if (any_i) begin
          if (!hit_i) begin
            st_d = LK_IDLE;
          end else if (idx_q == LastIdx) begin
            st_d = LK_OPEN;
          end else begin
            idx_d = idx_q + IDX_W'(1);
          end
        end
      end
      LK_OPEN: st_d = LK_IDLE;
      default: st_d = LK_IDLE;
    endcase
  end

  assign st_en  = (st_d != st_q);
  assign idx_en = (idx_d != idx_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= LK_IDLE;
    end else if (st_en) begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  assign st_o  = st_q;
  assign idx_o = idx_q;
endmodule

// File: rtl/color_code_lock.sv
module color_code_lock
  import color_lock_pkg::*;
#(
  parameter  int unsigned               CODE_LEN = 4,
  parameter  logic [CODE_LEN*COLOR_W-1:0] CODE_SEQ = 8'b00_01_10_00,
  localparam int unsigned               IDX_W    = $clog2(CODE_LEN)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic red_i,
  input  logic green_i,
  input  logic blue_i,
  input  logic any_i,
  output logic unlock_o
);
  logic                  rst_sync_n;
  logic [NUM_COLORS-1:0] color_vec;
  logic [NUM_COLORS-1:0] excl;
  logic                  hit;
  lock_state_e           lock_st;
  logic [IDX_W-1:0]      lock_idx;

  always_comb begin
    color_vec                 = '0;
    color_vec[int'(COL_RED)]   = red_i;
    color_vec[int'(COL_GREEN)] = green_i;
    color_vec[int'(COL_BLUE)]  = blue_i;
  end

  lock_rst_sync #(.STAGES(2)) u_rst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_sync_n)
  );

  press_decode u_dec (
    .any_i  (any_i),
    .color_i(color_vec),
    .excl_o (excl)
  );

  code_select #(.CODE_LEN(CODE_LEN), .CODE_SEQ(CODE_SEQ)) u_sel (
    .idx_i (lock_idx),
    .excl_i(excl),
    .hit_o (hit)
  );

  lock_fsm #(.CODE_LEN(CODE_LEN)) u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .start_i(start_i),
    .any_i  (any_i),
    .hit_i  (hit),
    .st_o   (lock_st),
    .idx_o  (lock_idx)
  );

  assign unlock_o = (lock_st == LK_OPEN);
endmodule

// File: rtl/color_code_lock_chk.sv
module color_code_lock_chk
  import color_lock_pkg::*;
#(
  parameter int unsigned IDX_W = 2
) (
  input logic             clk_i,
  input logic             rst_sync_n,
  input logic             start_i,
  input logic             red_i,
  input logic             green_i,
  input logic             blue_i,
  input logic             any_i,
  input logic             unlock_o,
  input lock_state_e      lock_st,
  input logic [IDX_W-1:0] lock_idx
);
  logic single_color;
  assign single_color = ($countones({red_i, green_i, blue_i}) == 1);

  p_reset_locked_r1: assert property (@(posedge clk_i)
    !rst_sync_n |-> !unlock_o);

  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (lock_st == LK_IDLE && !start_i) |=> (lock_st == LK_IDLE));

  p_idle_arm_r2: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (lock_st == LK_IDLE && start_i) |=> (lock_st == LK_ARMED && lock_idx == '0));

  p_gap_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (lock_st == LK_ARMED && !any_i) |=> (lock_st == LK_ARMED && $stable(lock_idx)));

  p_exclusive_step_r4: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    unlock_o |-> ($past(any_i) && $past(single_color)));

  p_bad_press_r5: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (lock_st == LK_ARMED && any_i && !single_color) |=> (lock_st == LK_IDLE));

  p_unlock_single_r6: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    unlock_o |=> (!unlock_o && lock_st == LK_IDLE));

  p_start_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (lock_st == LK_ARMED && start_i && !any_i) |=> $stable(lock_idx));
endmodule

bind color_code_lock color_code_lock_chk #(.IDX_W(IDX_W)) chk_i (
  .clk_i     (clk_i),
  .rst_sync_n(rst_sync_n),
  .start_i   (start_i),
  .red_i     (red_i),
  .green_i   (green_i),
  .blue_i    (blue_i),
  .any_i     (any_i),
  .unlock_o  (unlock_o),
  .lock_st   (lock_st),
  .lock_idx  (lock_idx)
);

// File: tb/color_code_lock_tb_top.sv
module color_code_lock_tb_top;
  logic clk = 1'b0;
  logic rst_ni;
  logic start, red, green, blue, any;
  logic unlock;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Model: -1 idle, 0..3 armed at that step, 4 open
  int mdl = -1;

  always #2.5 clk = ~clk;

  color_code_lock dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .start_i (start),
    .red_i   (red),
    .green_i (green),
    .blue_i  (blue),
    .any_i   (any),
    .unlock_o(unlock)
  );

  // Expected color for step k: red, blue, green, red
  function automatic bit step_ok(int k, logic r, logic g, logic b);
    case (k)
      0, 3:    return r && !g && !b;
      1:       return b && !r && !g;
      2:       return g && !r && !b;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s unlock actual=%b expected=%b (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic s, input logic r, input logic g, input logic b,
                      input logic a, input string tag);
    @(negedge clk);
    start = s; red = r; green = g; blue = b; any = a;
    @(posedge clk);
    if (mdl == -1) begin
      if (s) mdl = 0;
    end else if (mdl == 4) begin
      mdl = -1;
    end else if (a) begin
      if (step_ok(mdl, r, g, b)) mdl = (mdl == 3) ? 4 : mdl + 1;
      else mdl = -1;
    end
    #1;
    check(tag, unlock, (mdl == 4));
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, tag);
  endtask

  task automatic full_code(input string tag);
    step(0, 1, 0, 0, 1, tag);
    step(0, 0, 0, 1, 1, tag);
    step(0, 0, 1, 0, 1, tag);
    step(0, 1, 0, 0, 1, tag);
  endtask

  initial begin
    rst_ni = 1'b0;
    start = 0; red = 0; green = 0; blue = 0; any = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", unlock, 1'b0);
    rst_ni = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1", unlock, 1'b0);

    // R2: colored presses without start never unlock
    full_code("R2");
    idle(2, "R2");

    // R4 / R6: clean sequence, pulse one cycle then idle
    step(1, 0, 0, 0, 0, "R2");
    full_code("R4");
    step(0, 0, 0, 0, 0, "R6");
    idle(1, "R6");

    // R3: pauses, including color levels with any low
    step(1, 0, 0, 0, 0, "R3");
    idle(3, "R3");
    step(0, 1, 0, 0, 1, "R3");
    step(0, 0, 1, 0, 0, "R3");
    step(0, 1, 1, 1, 0, "R3");
    step(0, 0, 0, 1, 1, "R3");
    idle(2, "R3");
    step(0, 0, 1, 0, 1, "R3");
    step(0, 1, 0, 0, 1, "R3");
    idle(1, "R6");

    // R5: two colors at once on the blue step
    step(1, 0, 0, 0, 0, "R5");
    step(0, 1, 0, 0, 1, "R5");
    step(0, 1, 0, 1, 1, "R5");
    step(0, 0, 1, 0, 1, "R5");
    step(0, 1, 0, 0, 1, "R5");
    idle(1, "R5");

    // R5: wrong first color, then the rest of a correct code
    step(1, 0, 0, 0, 0, "R5");
    step(0, 0, 0, 1, 1, "R5");
    full_code("R5");
    idle(1, "R5");

    // R5: any high with no color
    step(1, 0, 0, 0, 0, "R5");
    step(0, 1, 0, 0, 1, "R5");
    step(0, 0, 0, 0, 1, "R5");
    step(0, 0, 1, 0, 1, "R5");
    step(0, 1, 0, 0, 1, "R5");
    idle(1, "R5");

    // R5: all colors on the last step
    step(1, 0, 0, 0, 0, "R5");
    step(0, 1, 0, 0, 1, "R5");
    step(0, 0, 0, 1, 1, "R5");
    step(0, 0, 1, 0, 1, "R5");
    step(0, 1, 1, 1, 1, "R5");
    idle(1, "R5");

    // R7: start presses mid-sequence are ignored
    step(1, 0, 0, 0, 0, "R7");
    step(0, 1, 0, 0, 1, "R7");
    step(1, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 1, 1, "R7");
    step(1, 0, 0, 0, 0, "R7");
    step(0, 0, 1, 0, 1, "R7");
    step(0, 1, 0, 0, 1, "R7");
    step(1, 0, 0, 0, 0, "R6");
    idle(1, "R6");

    // Fresh code right after a failure
    step(1, 0, 0, 0, 0, "R4");
    step(0, 0, 1, 0, 1, "R5");
    step(1, 0, 0, 0, 0, "R4");
    full_code("R4");
    idle(2, "R6");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired unlock actual=%b expected=done", unlock);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule